// File: doc/BRIEF.md
# Timer-Code Seed Assembler with CRC Check

This block builds a shift-register generator seed from the digitized codes of a set of slow timer channels. After a start strobe it reads a programmable list of channels one per cycle, through a single channel-select port. It concatenates the returned codes into one seed word, with the first channel read in the most significant field. A rotation setting shifts the read order cyclically, so the same channel set yields a different seed.

Once the seed is complete, the block runs a serial 3-bit CRC over its active bits. A peer that derived its own seed sends its CRC across the link. The block compares the two CRCs while its done pulse is high, which tells both sides whether they hold the same seed. A short mode uses one channel fewer and gives a shorter, right-aligned seed. Code conversion and the link itself are outside the block.

Top module: `seed_asm`

## Requirements
- R1: After reset, done_o, match_o and rd_en_o are low, and seed_o and crc_o are zero.
- R2: In full mode, n = SEQ_LEN = 7 channels are read. The code returned by read number i (i = 0 first) sits at seed_o[(n-1-i)*CODE_W +: CODE_W], so the 49-bit seed has the first read in its top field.
- R3: When short_i = 1 at start, n = SEQ_LEN-1 = 6 channels are read. The 42-bit seed is right-aligned in seed_o, and the bits above bit 41 are zero.
- R4: List entry k is idx_list_i[k*IDX_W +: IDX_W]. With r = rot_i mod n, read number p selects entry (p - r) mod n, so a rotation of 1 puts the last entry first. The list, mode and rotation are captured at the accepted start.
- R5: rd_en_o is high for exactly n consecutive cycles, beginning in the cycle after the start is sampled. In each of these cycles the block samples code_i for the channel on rd_ch_o in that same cycle.
- R6: crc_o equals the remainder of S(x)·x^3 divided by x^3+x+1, where S is the n·CODE_W-bit active seed taken as polynomial coefficients, most significant bit first, from a zero initial remainder.
- R7: done_o is a one-cycle pulse that rises n·(CODE_W+1) clock edges after the edge that samples start_i.
- R8: match_o is high only in the done cycle, and only when crc_o equals peer_crc_i.
- R9: A start_i pulse while an assembly is in progress has no effect. The running assembly completes with its original list, mode and rotation, and no second assembly follows.
- R10: After done, seed_o and crc_o hold their values, and rd_en_o stays low, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| short_i | input | 1 | 1 selects the one-channel-shorter seed |
| rot_i | input | ROT_W (3) | Cyclic rotation of the read order |
| idx_list_i | input | SEQ_LEN*IDX_W (28) | Channel index list, entry k in field k |
| rd_en_o | output | 1 | Channel read strobe |
| rd_ch_o | output | IDX_W (4) | Channel being read |
| code_i | input | CODE_W (7) | Code of the channel on rd_ch_o, same cycle |
| peer_crc_i | input | CRC_W (3) | CRC received from the peer |
| seed_o | output | SEQ_LEN*CODE_W (49) | Assembled seed |
| crc_o | output | CRC_W (3) | CRC remainder of the seed |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | CRC agrees with peer_crc_i, valid with done_o |

## Verification
The assertions take for granted that code_i is a valid function of rd_ch_o within each read cycle. They also assume peer_crc_i is steady around the done cycle, and that reset is released only while start_i is low. The bench drives code_i combinationally from a fixed per-channel model and changes peer_crc_i only between assemblies. It raises start_i only at falling edges, and only after reset. The sweep covers both lengths, every rotation value, including values at or above n, and several channel lists. It also injects stray start pulses mid-run, so the read-count and latency checks see both valid lengths.

// File: rtl/seed_asm_pkg.sv
package seed_asm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CRC  = 2'd2
  } state_e;
endpackage

// File: rtl/seed_asm_order.sv
// Maps read position to channel index: entry (pos - rot) mod n.
module seed_asm_order #(
  parameter int SEQ_LEN = 7,
  parameter int IDX_W   = 4,
  parameter int POS_W   = 3
) (
  input  logic [SEQ_LEN*IDX_W-1:0] list_i,
  input  logic [POS_W-1:0]         n_i,
  input  logic [POS_W-1:0]         rot_i,
  input  logic [POS_W-1:0]         pos_i,
  output logic [IDX_W-1:0]         ch_o
);
  logic [POS_W:0] sum;
  logic [POS_W:0] ent;

  always_comb begin
    sum = {1'b0, pos_i} + {1'b0, n_i} - {1'b0, rot_i};
    ent = (sum >= {1'b0, n_i}) ? sum - {1'b0, n_i} : sum;
  end

  always_comb begin
    ch_o = '0;
    for (int k = 0; k < SEQ_LEN; k++) begin
      if (ent == (POS_W+1)'(k)) ch_o = list_i[k*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/seed_asm_shreg.sv
// Seed register: shifts one code in per read, exposes a bit for the CRC.
module seed_asm_shreg #(
  parameter int SEQ_LEN = 7,
  parameter int CODE_W  = 7,
  localparam int SEED_W = SEQ_LEN * CODE_W,
  localparam int BIT_W  = $clog2(SEED_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  output logic [SEED_W-1:0] seed_o,
  output logic              bit_o
);
  logic [SEED_W-1:0] seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seed_q <= '0;
    else if (clr_i)   seed_q <= '0;
    else if (shift_i) seed_q <= {seed_q[SEED_W-CODE_W-1:0], code_i};
  end

  assign seed_o = seed_q;
  assign bit_o  = seed_q[bit_sel_i];
endmodule

// File: rtl/seed_asm_crc.sv
// Serial CRC, MSB first, zero initial value.
module seed_asm_crc #(
  parameter int               CRC_W = 3,
  parameter logic [CRC_W-1:0] POLY  = 3'b011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= (crc_q << 1) ^ ({CRC_W{fb}} & POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/seed_asm.sv
module seed_asm
  import seed_asm_pkg::*;
#(
  parameter int               NUM_CH   = 16,
  parameter int               SEQ_LEN  = 7,
  parameter int               CODE_W   = 7,
  parameter int               CRC_W    = 3,
  parameter logic [CRC_W-1:0] CRC_POLY = 3'b011,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ROT_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int SEED_W = SEQ_LEN * CODE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     short_i,
  input  logic [ROT_W-1:0]         rot_i,
  input  logic [SEQ_LEN*IDX_W-1:0] idx_list_i,
  output logic                     rd_en_o,
  output logic [IDX_W-1:0]         rd_ch_o,
  input  logic [CODE_W-1:0]        code_i,
  input  logic [CRC_W-1:0]         peer_crc_i,
  output logic [SEED_W-1:0]        seed_o,
  output logic [CRC_W-1:0]         crc_o,
  output logic                     done_o,
  output logic                     match_o
);
  localparam int POS_W      = $clog2(SEQ_LEN + 1);
  localparam int BIT_W      = $clog2(SEED_W + 1);
  localparam int BITS_FULL  = SEQ_LEN * CODE_W;
  localparam int BITS_SHORT = (SEQ_LEN - 1) * CODE_W;

  state_e                   state_q;
  logic [POS_W-1:0]         pos_q;
  logic [BIT_W-1:0]         cnt_q;
  logic                     done_q;
  logic                     short_q;
  logic [POS_W-1:0]         rot_q;
  logic [SEQ_LEN*IDX_W-1:0] list_q;

  logic [POS_W-1:0] n_in, n_q, rot_ext, rot_mod;
  logic             accept;
  logic             crc_bit;
  logic [CRC_W-1:0] crc_w;

  assign n_in    = short_i ? POS_W'(SEQ_LEN - 1) : POS_W'(SEQ_LEN);
  assign n_q     = short_q ? POS_W'(SEQ_LEN - 1) : POS_W'(SEQ_LEN);
  assign rot_ext = POS_W'(rot_i);
  // rot_i < 2^ROT_W <= 2*(SEQ_LEN-1), so one subtraction reduces it mod n
  assign rot_mod = (rot_ext >= n_in) ? rot_ext - n_in : rot_ext;
  assign accept  = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      short_q <= 1'b0;
      rot_q   <= '0;
      list_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            list_q  <= idx_list_i;
            short_q <= short_i;
            rot_q   <= rot_mod;
            pos_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          pos_q <= pos_q + POS_W'(1);
          if (pos_q == n_q - POS_W'(1)) begin
            cnt_q   <= short_q ? BIT_W'(BITS_SHORT - 1) : BIT_W'(BITS_FULL - 1);
            state_q <= ST_CRC;
          end
        end
        ST_CRC: begin
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - BIT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  seed_asm_order #(
    .SEQ_LEN(SEQ_LEN),
    .IDX_W  (IDX_W),
    .POS_W  (POS_W)
  ) u_order (
    .list_i(list_q),
    .n_i   (n_q),
    .rot_i (rot_q),
    .pos_i (pos_q),
    .ch_o  (rd_ch_o)
  );

  seed_asm_shreg #(
    .SEQ_LEN(SEQ_LEN),
    .CODE_W (CODE_W)
  ) u_shreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .shift_i  (state_q == ST_READ),
    .code_i   (code_i),
    .bit_sel_i(cnt_q),
    .seed_o   (seed_o),
    .bit_o    (crc_bit)
  );

  seed_asm_crc #(
    .CRC_W(CRC_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (state_q == ST_CRC),
    .bit_i (crc_bit),
    .crc_o (crc_w)
  );

  assign rd_en_o = (state_q == ST_READ);
  assign crc_o   = crc_w;
  assign done_o  = done_q;
  assign match_o = done_q && (crc_w == peer_crc_i);
endmodule

// File: rtl/seed_asm_chk.sv
module seed_asm_chk #(
  parameter int SEQ_LEN = 7,
  parameter int CODE_W  = 7,
  parameter int CRC_W   = 3,
  localparam int SEED_W = SEQ_LEN * CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_o,
  input logic [SEED_W-1:0] seed_o,
  input logic [CRC_W-1:0]  crc_o,
  input logic [CRC_W-1:0]  peer_crc_i,
  input logic              done_o,
  input logic              match_o
);
  logic        rd_en_d;
  logic        active;
  logic [15:0] cyc;
  logic [15:0] rdn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_d <= 1'b0;
      active  <= 1'b0;
      cyc     <= '0;
      rdn     <= '0;
    end else begin
      rd_en_d <= rd_en_o;
      if (rd_en_o && !rd_en_d) begin
        active <= 1'b1;
        cyc    <= 16'd1;
        rdn    <= 16'd1;
      end else if (active) begin
        cyc <= cyc + 16'd1;
        rdn <= rdn + {15'd0, rd_en_o};
        if (done_o) active <= 1'b0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_MATCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (done_o && crc_o == peer_crc_i)); // R8

  AST_SEED_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(seed_o) && $stable(crc_o)); // R10

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((rdn == 16'(SEQ_LEN) && cyc == 16'(SEQ_LEN*(CODE_W+1))) ||
                (rdn == 16'(SEQ_LEN-1) && cyc == 16'((SEQ_LEN-1)*(CODE_W+1))))); // R5

  AST_NO_READ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o); // R9
endmodule

bind seed_asm seed_asm_chk #(
  .SEQ_LEN(SEQ_LEN),
  .CODE_W (CODE_W),
  .CRC_W  (CRC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_o   (rd_en_o),
  .seed_o    (seed_o),
  .crc_o     (crc_o),
  .peer_crc_i(peer_crc_i),
  .done_o    (done_o),
  .match_o   (match_o)
);

// File: tb/seed_asm_tb.sv
module seed_asm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 16;
  localparam int IDX_W      = 4;
  localparam int SEQ_LEN    = 7;
  localparam int CODE_W     = 7;
  localparam int CRC_W      = 3;
  localparam int ROT_W      = 3;
  localparam int SEED_W     = SEQ_LEN * CODE_W;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start = 1'b0;
  logic                     short_m = 1'b0;
  logic [ROT_W-1:0]         rot = '0;
  logic [SEQ_LEN*IDX_W-1:0] list = '0;
  logic                     rd_en;
  logic [IDX_W-1:0]         rd_ch;
  logic [CODE_W-1:0]        code;
  logic [CRC_W-1:0]         peer = '0;
  logic [SEED_W-1:0]        seed;
  logic [CRC_W-1:0]         crc;
  logic                     done;
  logic                     match;
  logic [CODE_W-1:0]        salt = '0;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CODE_W-1:0] code_of(logic [IDX_W-1:0] ch, logic [CODE_W-1:0] s);
    int v;
    v = int'(ch) * 13 + int'(ch) * int'(ch) + int'(s) * 5;
    return CODE_W'(v);
  endfunction

  assign code = code_of(rd_ch, salt);

  seed_asm dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .short_i   (short_m),
    .rot_i     (rot),
    .idx_list_i(list),
    .rd_en_o   (rd_en),
    .rd_ch_o   (rd_ch),
    .code_i    (code),
    .peer_crc_i(peer),
    .seed_o    (seed),
    .crc_o     (crc),
    .done_o    (done),
    .match_o   (match)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SEQ_LEN*IDX_W-1:0] make_list(int li);
    logic [SEQ_LEN*IDX_W-1:0] l;
    int a, b;
    a = 3 + 2 * li;
    b = 1 + 4 * li;
    for (int k = 0; k < SEQ_LEN; k++) l[k*IDX_W +: IDX_W] = IDX_W'((k * a + b) % NUM_CH);
    return l;
  endfunction

  // polynomial long division of S(x)*x^3 by x^3+x+1
  function automatic logic [CRC_W-1:0] ref_crc(longint unsigned s);
    longint unsigned m;
    m = s << 3;
    for (int i = 63; i >= 3; i--) begin
      if (m[i]) m = m ^ (64'hB << (i - 3));
    end
    return m[2:0];
  endfunction

  task automatic run_case(bit sh, int r, int li, bit flip, bit mid);
    int n, rm, k, p;
    logic [SEQ_LEN*IDX_W-1:0] l;
    logic [IDX_W-1:0] exp_ch[SEQ_LEN];
    longint unsigned exp_seed;
    logic [CRC_W-1:0] exp_crc;
    logic [SEED_W-1:0] seed_hold;
    logic [CRC_W-1:0] crc_hold;
    bit order_ok, match_early;
    n  = sh ? SEQ_LEN - 1 : SEQ_LEN;
    rm = r % n;
    l  = make_list(li);
    exp_seed = 0;
    for (int q = 0; q < n; q++) begin
      exp_ch[q] = l[((q + n - rm) % n)*IDX_W +: IDX_W];
      exp_seed  = (exp_seed << CODE_W) | longint'(code_of(exp_ch[q], salt));
    end
    exp_crc = ref_crc(exp_seed);

    @(negedge clk);
    short_m = sh;
    rot     = ROT_W'(r);
    list    = l;
    peer    = exp_crc ^ CRC_W'(flip);
    start   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start   = 1'b0;
    list    = ~l;      // captured list must be used
    rot     = ROT_W'(r + 1);
    short_m = ~sh;
    k = 1; p = 0; order_ok = 1; match_early = 0;
    forever begin
      if (rd_en) begin
        if (p >= n || rd_ch !== exp_ch[p]) order_ok = 0;
        p++;
      end
      if (done) break;
      if (match) match_early = 1;
      start = mid && (k == 2);
      if (k > 200) break;
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(order_ok, "R4 read order", longint'(rd_ch), longint'(exp_ch[0]));
    chk(p == n, "R5 read count", p, n);
    chk(k - 1 == n * (CODE_W + 1), "R7 done latency", k - 1, n * (CODE_W + 1));
    if (sh) chk(seed === SEED_W'(exp_seed), "R3 short seed", longint'(seed), exp_seed);
    else    chk(seed === SEED_W'(exp_seed), "R2 full seed", longint'(seed), exp_seed);
    chk(crc === exp_crc, "R6 crc", crc, exp_crc);
    chk(match === !flip, "R8 match at done", match, !flip);
    chk(!match_early, "R8 match before done", match_early, 0);
    if (mid) chk(p == n && seed === SEED_W'(exp_seed), "R9 start ignored", longint'(seed), exp_seed);
    seed_hold = seed;
    crc_hold  = crc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !rd_en && !match, "R10 idle after done", {done, rd_en, match}, 0);
    chk(seed === seed_hold && crc === crc_hold, "R10 hold", longint'(seed), longint'(seed_hold));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !match && !rd_en, "R1 reset flags", {done, match, rd_en}, 0);
    chk(seed == '0 && crc == '0, "R1 reset data", longint'(seed), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !rd_en && seed == '0, "R1 after release", longint'(seed), 0);
    for (int sh = 0; sh < 2; sh++) begin
      for (int r = 0; r < 8; r++) begin
        for (int li = 0; li < 3; li++) begin
          salt = CODE_W'(r * 11 + li * 7 + sh * 3);
          run_case(sh[0], r, li, 1'((r + li) % 2), r == 3);
        end
      end
    end
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule